// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit side of a packet DMA engine. Software builds a ring of 32-byte descriptors in memory, points the engine at the ring with a base-load strobe, and pulses a poll request. The engine then follows the ring from its current position. For each descriptor that is owned by hardware, it fetches the buffer bytes into an on-chip staging memory. When a descriptor carries the last-segment mark, it plays the gathered frame out on a byte stream. It then hands the descriptor back to software by clearing the ownership bit in word 0 and moves to the next slot, or back to the base when the slot is marked as the end of the ring.

Memory is reached through one word-wide request port. A request is held until it is acknowledged, and read data is taken in the acknowledge cycle. A pass ends silently when the engine meets a descriptor it does not own, or one whose sizes are malformed. A poll that arrives during a pass is remembered, and it causes exactly one further pass.

Top module: `tx_ring_walker`

## Requirements
- R1: After reset there is no memory request, `tx_valid_o` is low and `tx_done_o` is low.
- R2: A poll while idle starts a pass with a read of word 0 at the current pointer. If bit 31 (ownership) of that word is clear, the pass ends with no write to memory.
- R3: The buffer length is bits 11:0 of word 1, and bits 15:12 of word 1 are ignored. The buffer address is word 2. Byte i of the buffer is read from the word holding address+i, on byte lane (address+i) mod 4, with lane 0 at bits 7:0.
- R4: A pass ends with no write-back and no pointer change if the buffer length exceeds 2048, if bits 27:16 of word 1 are nonzero, or if the staged count plus the length would reach 8192. A length of exactly 2048 is accepted. The staging count is empty at the start of every pass.
- R5: When bit 29 of word 0 is set, all bytes staged since the last frame are sent in order, with `tx_last_o` on the final byte. The data and last flag hold while `tx_ready_i` is low.
- R6: `tx_done_o` pulses for one cycle, in the cycle after the final byte of a frame is accepted. It is low at all other times.
- R7: Each accepted descriptor is written back after any frame it closes has been sent. Only word 0 is written, with bit 31 cleared and all other bits kept.
- R8: After a write-back the pointer reloads from the base if bit 21 of word 0 was set. Otherwise it advances by 32.
- R9: The base-load strobe sets both the base and the current pointer while idle. It is ignored during a pass.
- R10: Any number of polls during a pass cause exactly one more pass after it.
- R11: A memory request keeps its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_i | input | 1 | Poll request pulse |
| base_wr_i | input | 1 | Load ring base and current pointer |
| base_addr_i | input | ADDR_W | Ring base byte address |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Byte valid |
| tx_last_o | output | 1 | Final byte of frame |
| tx_ready_i | input | 1 | Sink accepts byte |
| tx_done_o | output | 1 | Frame sent pulse |

## Verification
Two situations are the hardest to reach from the ports. The first is the staging limit, which needs 8192 bytes across several descriptors. Four descriptors share one 2048-byte buffer, so the fourth is refused and then accepted alone by a fresh pass. The second is a burst of polls landing inside a running pass. The polls are timed a few cycles after the first one, and the bench counts reads of the terminating descriptor's word 0 to see that exactly one extra pass ran. A base load issued in the same window must leave no read at the new address. Memory acknowledges are delayed pseudo-randomly, and sink ready toggles on a fixed pattern throughout the run.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CTL, ST_RD_SIZE, ST_RD_ADDR,
    ST_COPY, ST_SEND_GO, ST_SEND_WAIT, ST_WB
  } walk_state_e;

  localparam int unsigned OWN_BIT  = 31;
  localparam int unsigned LAST_BIT = 29;
  localparam int unsigned WRAP_BIT = 21;
  localparam int unsigned LEN_W    = 12;
endpackage

// File: rtl/tx_stage_buf.sv
module tx_stage_buf #(
  parameter int unsigned DEPTH = 8192,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);
  localparam int unsigned NB    = 4;
  localparam int unsigned BSEL  = $clog2(NB);
  localparam int unsigned ROWS  = DEPTH / NB;

  logic [7:0] bank_rd [NB];

  // byte lanes split by low index bits
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [7:0] mem [ROWS];
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i[BSEL-1:0] == BSEL'(b)))
        mem[waddr_i[IDX_W-1:BSEL]] <= wdata_i;
    end
    assign bank_rd[b] = mem[raddr_i[IDX_W-1:BSEL]];
  end

  assign rdata_o = bank_rd[raddr_i[BSEL-1:0]];
endmodule

// File: rtl/tx_stream_out.sv
module tx_stream_out #(
  parameter int unsigned MAX_FRAME = 8192,
  localparam int unsigned IDX_W = $clog2(MAX_FRAME),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  logic             active_q, done_q;
  logic [CNT_W-1:0] idx_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        idx_q    <= '0;
        len_q    <= len_i;
        active_q <= (len_i != '0);
        done_q   <= (len_i == '0);
      end else if (active_q && ready_i) begin
        if (idx_q == len_q - CNT_W'(1)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          idx_q <= idx_q + CNT_W'(1);
        end
      end
    end
  end

  assign valid_o = active_q;
  assign last_o  = active_q && (idx_q == len_q - CNT_W'(1));
  assign idx_o   = idx_q[IDX_W-1:0];
  assign done_o  = done_q;

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(idx_o) && $stable(last_o)));

  assert_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(valid_o && ready_i && last_o) || $past(start_i && (len_i == '0))));
endmodule

// File: rtl/tx_ring_fsm.sv
module tx_ring_fsm
  import tx_ring_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned MAX_FRAME  = 8192,
  parameter int unsigned MAX_BUF1   = 2048,
  parameter int unsigned DESC_BYTES = 32,
  localparam int unsigned IDX_W = $clog2(MAX_FRAME),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_i,
  input  logic              base_wr_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              stage_we_o,
  output logic [IDX_W-1:0]  stage_waddr_o,
  output logic [7:0]        stage_wdata_o,
  output logic              send_start_o,
  output logic [CNT_W-1:0]  send_len_o,
  input  logic              send_done_i
);
  walk_state_e       state_q;
  logic [ADDR_W-1:0] base_q, cur_q, buf_q;
  logic [31:0]       ctl_q;
  logic [LEN_W-1:0]  len_q, bidx_q;
  logic [CNT_W-1:0]  fcnt_q;
  logic              pend_q;

  logic [LEN_W-1:0]  b1_len, b2_len;
  logic [CNT_W-1:0]  fsum;
  logic              size_bad, restart, busy;
  logic [ADDR_W-1:0] byte_addr;
  logic [1:0]        lane;

  assign b1_len    = mem_rdata_i[LEN_W-1:0];
  assign b2_len    = mem_rdata_i[16 +: LEN_W];
  assign fsum      = fcnt_q + CNT_W'(b1_len);
  assign size_bad  = (b1_len > LEN_W'(MAX_BUF1)) || (b2_len != '0) ||
                     (fsum >= CNT_W'(MAX_FRAME));
  assign restart   = pend_q | poll_i;
  assign busy      = (state_q != ST_IDLE);
  assign byte_addr = buf_q + ADDR_W'(bidx_q);
  assign lane      = byte_addr[1:0];

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = cur_q;
    case (state_q)
      ST_RD_CTL:  mem_req_o = 1'b1;
      ST_RD_SIZE: begin mem_req_o = 1'b1; mem_addr_o = cur_q + ADDR_W'(4); end
      ST_RD_ADDR: begin mem_req_o = 1'b1; mem_addr_o = cur_q + ADDR_W'(8); end
      ST_COPY:    begin mem_req_o = 1'b1; mem_addr_o = {byte_addr[ADDR_W-1:2], 2'b00}; end
      ST_WB:      begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      default: ;
    endcase
  end

  assign mem_wdata_o   = ctl_q & ~(32'h1 << OWN_BIT);
  assign stage_we_o    = (state_q == ST_COPY) && mem_ack_i;
  assign stage_waddr_o = fcnt_q[IDX_W-1:0];
  assign stage_wdata_o = mem_rdata_i[{lane, 3'b000} +: 8];
  assign send_start_o  = (state_q == ST_SEND_GO);
  assign send_len_o    = fcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      cur_q   <= '0;
      buf_q   <= '0;
      ctl_q   <= '0;
      len_q   <= '0;
      bidx_q  <= '0;
      fcnt_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (poll_i && busy) pend_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (base_wr_i) begin
            base_q <= base_addr_i;
            cur_q  <= base_addr_i;
          end
          if (poll_i) begin
            state_q <= ST_RD_CTL;
            fcnt_q  <= '0;
          end
        end
        ST_RD_CTL: if (mem_ack_i) begin
          ctl_q <= mem_rdata_i;
          if (mem_rdata_i[OWN_BIT]) begin
            state_q <= ST_RD_SIZE;
          end else begin
            state_q <= restart ? ST_RD_CTL : ST_IDLE;
            pend_q  <= 1'b0;
            fcnt_q  <= '0;
          end
        end
        ST_RD_SIZE: if (mem_ack_i) begin
          if (size_bad) begin
            state_q <= restart ? ST_RD_CTL : ST_IDLE;
            pend_q  <= 1'b0;
            fcnt_q  <= '0;
          end else begin
            len_q   <= b1_len;
            state_q <= ST_RD_ADDR;
          end
        end
        ST_RD_ADDR: if (mem_ack_i) begin
          buf_q  <= mem_rdata_i[ADDR_W-1:0];
          bidx_q <= '0;
          if (len_q == '0) state_q <= ctl_q[LAST_BIT] ? ST_SEND_GO : ST_WB;
          else             state_q <= ST_COPY;
        end
        ST_COPY: if (mem_ack_i) begin
          fcnt_q <= fcnt_q + CNT_W'(1);
          if (bidx_q == len_q - LEN_W'(1)) state_q <= ctl_q[LAST_BIT] ? ST_SEND_GO : ST_WB;
          else                             bidx_q  <= bidx_q + LEN_W'(1);
        end
        ST_SEND_GO: state_q <= ST_SEND_WAIT;
        ST_SEND_WAIT: if (send_done_i) begin
          fcnt_q  <= '0;
          state_q <= ST_WB;
        end
        ST_WB: if (mem_ack_i) begin
          cur_q   <= ctl_q[WRAP_BIT] ? base_q : cur_q + ADDR_W'(DESC_BYTES);
          state_q <= ST_RD_CTL;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_ptr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy) && !$stable(cur_q)) |->
      ((cur_q == $past(cur_q) + ADDR_W'(DESC_BYTES)) || (cur_q == base_q)));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcnt_q < CNT_W'(MAX_FRAME));
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MAX_FRAME = 8192,
  parameter int unsigned MAX_BUF1  = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_i,
  input  logic              base_wr_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i,
  output logic              tx_done_o
);
  localparam int unsigned IDX_W = $clog2(MAX_FRAME);
  localparam int unsigned CNT_W = IDX_W + 1;

  logic             stage_we;
  logic [IDX_W-1:0] stage_waddr, stage_raddr;
  logic [7:0]       stage_wdata;
  logic             send_start, send_done;
  logic [CNT_W-1:0] send_len;

  tx_ring_fsm #(
    .ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME), .MAX_BUF1(MAX_BUF1), .DESC_BYTES(32)
  ) u_fsm (
    .clk_i, .rst_ni, .poll_i, .base_wr_i, .base_addr_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .stage_we_o(stage_we), .stage_waddr_o(stage_waddr), .stage_wdata_o(stage_wdata),
    .send_start_o(send_start), .send_len_o(send_len), .send_done_i(send_done)
  );

  tx_stage_buf #(.DEPTH(MAX_FRAME)) u_stage (
    .clk_i, .we_i(stage_we), .waddr_i(stage_waddr), .wdata_i(stage_wdata),
    .raddr_i(stage_raddr), .rdata_o(tx_data_o)
  );

  tx_stream_out #(.MAX_FRAME(MAX_FRAME)) u_out (
    .clk_i, .rst_ni, .start_i(send_start), .len_i(send_len), .ready_i(tx_ready_i),
    .valid_o(tx_valid_o), .last_o(tx_last_o), .idx_o(stage_raddr), .done_o(send_done)
  );

  assign tx_done_o = send_done;
endmodule

// File: tb/tx_ring_walker_tb_top.sv
module tx_ring_walker_tb_top;
  localparam int MW = 4096;
  localparam logic [31:0] OWN = 32'h8000_0000, LS = 32'h2000_0000, EOR = 32'h0020_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        poll = 1'b0, base_wr = 1'b0;
  logic [31:0] base_addr = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, tx_ready = 1'b0, tx_done;

  tx_ring_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .poll_i(poll), .base_wr_i(base_wr), .base_addr_i(base_addr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last), .tx_ready_i(tx_ready),
    .tx_done_o(tx_done)
  );

  logic [31:0] mem [MW];
  int          rd_cnt [MW];
  int          wr_cnt = 0, done_cnt = 0;
  int          checks = 0, fails = 0;
  logic [8:0]  expq [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int widx(input logic [31:0] a);
    return int'(a[13:2]);
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) ^ (a >> 5));
  endfunction

  // memory model: pseudo-random ack delay
  int unsigned seed = 32'h1234_5678;
  bit          prev_wait = 1'b0, prev_we = 1'b0;
  logic [31:0] prev_addr = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      prev_wait = 1'b0;
    end else begin
      if (prev_wait)
        chk(mem_req && mem_addr == prev_addr && mem_we == prev_we, "R11 request held", mem_addr, prev_addr);
      seed = seed * 32'd1103515245 + 32'd12345;
      if (mem_req && ((seed >> 16) % 3 != 0)) begin
        mem_ack   = 1'b1;
        mem_rdata = mem[widx(mem_addr)];
        if (mem_we) begin
          mem[widx(mem_addr)] = mem_wdata;
          wr_cnt++;
        end else begin
          rd_cnt[widx(mem_addr)]++;
        end
        prev_wait = 1'b0;
      end else begin
        mem_ack   = 1'b0;
        prev_wait = mem_req;
        prev_addr = mem_addr;
        prev_we   = mem_we;
      end
    end
  end

  // sink: ready pattern and scoreboard monitor
  int rp = 0;
  bit exp_done = 1'b0;
  always @(negedge clk) begin
    rp++;
    tx_ready = ((rp % 5) != 2) && ((rp % 7) != 3);
    #1;
    if (rst_n) begin
      if (tx_done) done_cnt++;
      if (exp_done) begin
        chk(tx_done, "R6 done after last byte", 32'(tx_done), 32'd1);
        exp_done = 1'b0;
      end else if (tx_done) begin
        chk(1'b0, "R6 stray done", 32'(tx_done), 32'd0);
      end
      if (tx_valid && tx_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R5 unexpected byte", {23'd0, tx_last, tx_data}, 32'h0);
        end else begin
          logic [8:0] e;
          e = expq.pop_front();
          chk({tx_last, tx_data} == e, "R5 frame byte", {23'd0, tx_last, tx_data}, {23'd0, e});
          if (e[8]) exp_done = 1'b1;
        end
      end
    end
  end

  task automatic set_desc(input logic [31:0] a, input logic [31:0] ctl, input logic [31:0] w1,
                          input logic [31:0] ba);
    mem[widx(a)]     = ctl;
    mem[widx(a) + 1] = w1;
    mem[widx(a) + 2] = ba;
    for (int k = 3; k < 8; k++) mem[widx(a) + k] = '0;
  endtask

  task automatic push_seg(input int ba, input int len, input bit closes);
    for (int i = 0; i < len; i++)
      expq.push_back({closes && (i == len - 1), pat(ba + i)});
  endtask

  task automatic do_poll();
    @(negedge clk) poll = 1'b1;
    @(negedge clk) poll = 1'b0;
  endtask

  task automatic load_base(input logic [31:0] a);
    @(negedge clk) begin base_wr = 1'b1; base_addr = a; end
    @(negedge clk) base_wr = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 16) begin
      @(negedge clk);
      #2;
      if (!mem_req && !tx_valid) q++;
      else q = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int w0, d0, r0, r1;
    for (int w = 0; w < MW; w++) begin
      mem[w] = '0;
      rd_cnt[w] = 0;
    end
    for (int w = 32'h800; w < MW; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};

    repeat (5) @(negedge clk);
    #2;
    chk(!mem_req && !tx_valid && !tx_done, "R1 reset outputs", {29'd0, mem_req, tx_valid, tx_done}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(!mem_req && !tx_valid && !tx_done, "R1 idle after reset", {29'd0, mem_req, tx_valid, tx_done}, 32'd0);

    // two-segment frame, unaligned buffers
    load_base(32'h100);
    set_desc(32'h100, OWN | 32'hA5, 32'd5, 32'h2001);
    set_desc(32'h120, OWN | LS | 32'h5A00, 32'h0000_F003, 32'h2103);
    set_desc(32'h140, 32'h11, 32'd4, 32'h2200);
    push_seg(32'h2001, 5, 1'b0);
    push_seg(32'h2103, 3, 1'b1);
    w0 = wr_cnt; d0 = done_cnt;
    do_poll();
    wait_quiet();
    chk(expq.size() == 0, "R3 all gathered bytes sent", expq.size(), 0);
    chk(done_cnt - d0 == 1, "R6 one done per frame", done_cnt - d0, 1);
    chk(mem[widx(32'h100)] == 32'hA5, "R7 own cleared d0", mem[widx(32'h100)], 32'hA5);
    chk(mem[widx(32'h120)] == (LS | 32'h5A00), "R7 own cleared d1", mem[widx(32'h120)], LS | 32'h5A00);
    chk(mem[widx(32'h124)] == 32'h0000_F003, "R7 word1 untouched", mem[widx(32'h124)], 32'h0000_F003);
    chk(mem[widx(32'h140)] == 32'h11, "R2 unowned untouched", mem[widx(32'h140)], 32'h11);
    chk(wr_cnt - w0 == 2, "R2 writes only owned", wr_cnt - w0, 2);
    chk(rd_cnt[widx(32'h100)] == 1, "R9 pass began at base", rd_cnt[widx(32'h100)], 1);

    // advance to third slot, then wrap on end-of-ring mark
    set_desc(32'h140, OWN | LS | EOR, 32'd4, 32'h2200);
    push_seg(32'h2200, 4, 1'b1);
    do_poll();
    wait_quiet();
    chk(expq.size() == 0, "R8 advanced slot sent", expq.size(), 0);
    chk(mem[widx(32'h140)] == (LS | EOR), "R7 wrap slot written", mem[widx(32'h140)], LS | EOR);
    chk(rd_cnt[widx(32'h100)] == 2, "R8 wrapped to base", rd_cnt[widx(32'h100)], 2);
    chk(rd_cnt[widx(32'h160)] == 0, "R8 no step past wrap", rd_cnt[widx(32'h160)], 0);

    // malformed sizes
    set_desc(32'h100, OWN | LS, 32'd2049, 32'h2300);
    w0 = wr_cnt; d0 = done_cnt;
    do_poll();
    wait_quiet();
    chk(wr_cnt == w0, "R4 oversize no writeback", wr_cnt - w0, 0);
    chk(mem[widx(32'h100)] == (OWN | LS), "R4 oversize owned", mem[widx(32'h100)], OWN | LS);
    mem[widx(32'h104)] = 32'h0001_0002;
    do_poll();
    wait_quiet();
    chk(wr_cnt == w0, "R4 second buffer no writeback", wr_cnt - w0, 0);
    chk(done_cnt == d0, "R4 no frame", done_cnt - d0, 0);
    chk(rd_cnt[widx(32'h100)] == 4, "R4 pointer unchanged", rd_cnt[widx(32'h100)], 4);
    mem[widx(32'h104)] = 32'd2;
    push_seg(32'h2300, 2, 1'b1);
    do_poll();
    wait_quiet();
    chk(expq.size() == 0 && wr_cnt - w0 == 1, "R4 fixed slot accepted", wr_cnt - w0, 1);

    // staging limit: 3 x 2048 accepted, fourth refused, then alone accepted
    set_desc(32'h120, OWN, 32'd2048, 32'h2000);
    set_desc(32'h140, OWN, 32'd2048, 32'h2000);
    set_desc(32'h160, OWN, 32'd2048, 32'h2000);
    set_desc(32'h180, OWN | LS, 32'd2048, 32'h2000);
    w0 = wr_cnt; d0 = done_cnt;
    do_poll();
    wait_quiet();
    chk(wr_cnt - w0 == 3, "R4 limit writebacks", wr_cnt - w0, 3);
    chk(mem[widx(32'h180)] == (OWN | LS), "R4 limit slot kept", mem[widx(32'h180)], OWN | LS);
    chk(done_cnt == d0, "R4 limit no frame", done_cnt - d0, 0);
    push_seg(32'h2000, 2048, 1'b1);
    do_poll();
    wait_quiet();
    chk(expq.size() == 0, "R4 fresh pass sends 2048", expq.size(), 0);
    chk(done_cnt - d0 == 1, "R4 fresh pass done", done_cnt - d0, 1);
    chk(mem[widx(32'h180)] == LS, "R7 limit slot written", mem[widx(32'h180)], LS);

    // polls and base load during a pass
    set_desc(32'h1A0, OWN | LS, 32'd6, 32'h2400);
    set_desc(32'h1C0, 32'h0, 32'd0, 32'h0);
    push_seg(32'h2400, 6, 1'b1);
    r0 = rd_cnt[widx(32'h1C0)];
    do_poll();
    repeat (2) @(negedge clk);
    poll = 1'b1;
    repeat (2) @(negedge clk);
    poll = 1'b0;
    load_base(32'h300);
    wait_quiet();
    chk(expq.size() == 0, "R10 frame during polls", expq.size(), 0);
    chk(rd_cnt[widx(32'h1C0)] - r0 == 2, "R10 exactly one extra pass", rd_cnt[widx(32'h1C0)] - r0, 2);
    chk(rd_cnt[widx(32'h300)] == 0, "R9 busy base load ignored", rd_cnt[widx(32'h300)], 0);
    r1 = rd_cnt[widx(32'h1C0)];
    do_poll();
    wait_quiet();
    chk(rd_cnt[widx(32'h1C0)] - r1 == 1, "R2 idle poll single pass", rd_cnt[widx(32'h1C0)] - r1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule